// File: doc/BRIEF.md
# Carry-Save Multi-Operand Adder

This block adds a fixed number of unsigned operands of equal width in a single pass and returns their exact total. All operands arrive together on one flat input vector. The block never adds two operands at a time with a full carry chain. Instead it runs a linear chain of carry-save rows. Each row takes three values and leaves two: a sum vector and a carry vector that has been moved up one column. Only the last pair goes through a single carry-propagate adder, which turns the redundant form into an ordinary binary number.

The result is wide enough that the largest possible total never wraps. With two operands there are no carry-save rows, and the block is just the final adder. An optional output register, with a valid flag that travels beside the data, can be kept or removed with a parameter. This lets the same unit sit inside a pipelined datapath or inside a purely combinational one.

Top module: `mop_adder_top`

## Requirements
- R1: With NUM_OPS operands of OP_W bits, where operand i occupies bits [i*OP_W +: OP_W] of `operands`, the result is their exact unsigned total on OP_W + ceil(log2 NUM_OPS) bits.
- R2: Every carry-save row takes inputs x, y and z. Its sum vector plus its carry vector equals x + y + z, modulo the result width. Bit 0 of the carry vector is always 0, because the carry vector carries double weight. No row passes a carry sideways between columns.
- R3: The single final carry-propagate adder outputs the wrapped sum of the last redundant pair.
- R4: With PIPE = 1, an operand set presented with `in_valid` high at a clock edge shows up on `sum`, with `out_valid` high, after that edge. Back-to-back valid cycles each give their own result one cycle later.
- R5: With four 4-bit operands 0001, 0111, 1101 and 0010, the result is 10111 (decimal 23).
- R6: With NUM_OPS = 2 there is no carry-save row, and the result comes straight from one adder. 255 + 255 gives 510 on 9 bits.
- R7: When every operand is all ones, the result is NUM_OPS*(2^OP_W - 1) without wrapping. This is 1275 for five 8-bit operands and 60 for four 4-bit operands.
- R8: While `rst_n` is low, `out_valid` and `sum` are 0 on the registered variant, even if `in_valid` is high.
- R9: With PIPE = 1, a cycle with `in_valid` low gives `out_valid` low after the edge. `sum` keeps its last value regardless of the operands.
- R10: With PIPE = 0, `out_valid` equals `in_valid`, and `sum` follows the operands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand set on `operands` is valid |
| operands | input | NUM_OPS*OP_W | All operands, operand 0 in the least significant bits |
| out_valid | output | 1 | `sum` holds a fresh total |
| sum | output | OP_W+ceil(log2 NUM_OPS) | Exact total of the operands |

## Verification
Two functions can coincide in one cycle on the registered variant. A new operand set can be accepted while the previous total is being presented, and reset can arrive while `in_valid` is high. The bench streams valid sets on consecutive cycles and checks that each total appears exactly one cycle after its own set, never the neighbour's. It then drives `in_valid` high during a reset pulse and requires both outputs to read zero, so reset always wins. The arithmetic is judged against totals that the bench adds up itself, over a fixed table, random sets, all-ones sets and the two-operand and combinational variants.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Output width needed so that k operands of n bits never wrap.
  function automatic int total_width(input int n, input int k);
    return n + $clog2(k);
  endfunction

  // One column of a full adder: parity of the three inputs.
  function automatic logic fa_sum(input logic a, input logic b, input logic ci);
    return a ^ b ^ ci;
  endfunction

  // One column of a full adder: majority of the three inputs.
  function automatic logic fa_carry(input logic a, input logic b, input logic ci);
    return (a & b) | (ci & (a ^ b));
  endfunction

endpackage

// File: rtl/mop_csa_row.sv
// One carry-save row: W independent full adders, carry vector pre-shifted
// left by one column. The carry out of the top column is dropped; the final
// total is exact modulo 2^W and W is sized so the true total fits.
module mop_csa_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  import csa_pkg::*;

  assign c[0] = 1'b0;

  for (genvar bi = 0; bi < W; bi++) begin : g_col
    assign s[bi] = fa_sum(x[bi], y[bi], z[bi]);
    if (bi < W - 1) begin : g_up
      assign c[bi+1] = fa_carry(x[bi], y[bi], z[bi]);
    end
  end

endmodule

// File: rtl/mop_cpa.sv
// Final carry-propagate adder: a ripple chain of full adders, W bits wide,
// wrapping modulo 2^W.
module mop_cpa #(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res
);
  import csa_pkg::*;

  logic [W-1:0] cy;

  assign cy[0] = 1'b0;

  for (genvar bi = 0; bi < W; bi++) begin : g_col
    assign res[bi] = fa_sum(opa[bi], opb[bi], cy[bi]);
    if (bi < W - 1) begin : g_up
      assign cy[bi+1] = fa_carry(opa[bi], opb[bi], cy[bi]);
    end
  end

endmodule

// File: rtl/mop_adder_top.sv
module mop_adder_top #(
  parameter int NUM_OPS = 5,
  parameter int OP_W    = 8,
  parameter bit PIPE    = 1'b1,
  localparam int OUT_W  = csa_pkg::total_width(OP_W, NUM_OPS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [NUM_OPS*OP_W-1:0] operands,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        sum
);

  localparam int NSTG     = NUM_OPS - 2;
  localparam int NSTG_ARR = (NSTG > 0) ? NSTG : 1;

  // Zero-extended operands at the full result width.
  logic [OUT_W-1:0] op_ext [NUM_OPS];

  // Named internal events for the checker: per-row inputs and outputs,
  // packed row by row, plus the final adder's operands and result.
  logic [NSTG_ARR*OUT_W-1:0] stg_x;
  logic [NSTG_ARR*OUT_W-1:0] stg_y;
  logic [NSTG_ARR*OUT_W-1:0] stg_z;
  logic [NSTG_ARR*OUT_W-1:0] stg_s;
  logic [NSTG_ARR*OUT_W-1:0] stg_c;
  logic [OUT_W-1:0]          cpa_a;
  logic [OUT_W-1:0]          cpa_b;
  logic [OUT_W-1:0]          cpa_y;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_ext
    assign op_ext[i] = {{(OUT_W-OP_W){1'b0}}, operands[i*OP_W +: OP_W]};
  end

  if (NSTG == 0) begin : g_pair
    // Two operands: no reduction, the final adder does all the work.
    assign stg_x = '0;
    assign stg_y = '0;
    assign stg_z = '0;
    assign stg_s = '0;
    assign stg_c = '0;
    assign cpa_a = op_ext[0];
    assign cpa_b = op_ext[1];
  end else begin : g_chain
    for (genvar j = 0; j < NSTG; j++) begin : g_row
      if (j == 0) begin : g_head
        assign stg_x[0 +: OUT_W] = op_ext[0];
        assign stg_y[0 +: OUT_W] = op_ext[1];
      end else begin : g_link
        assign stg_x[j*OUT_W +: OUT_W] = stg_s[(j-1)*OUT_W +: OUT_W];
        assign stg_y[j*OUT_W +: OUT_W] = stg_c[(j-1)*OUT_W +: OUT_W];
      end
      assign stg_z[j*OUT_W +: OUT_W] = op_ext[j+2];

      mop_csa_row #(.W(OUT_W)) row_i (
        .x (stg_x[j*OUT_W +: OUT_W]),
        .y (stg_y[j*OUT_W +: OUT_W]),
        .z (stg_z[j*OUT_W +: OUT_W]),
        .s (stg_s[j*OUT_W +: OUT_W]),
        .c (stg_c[j*OUT_W +: OUT_W])
      );
    end
    assign cpa_a = stg_s[(NSTG-1)*OUT_W +: OUT_W];
    assign cpa_b = stg_c[(NSTG-1)*OUT_W +: OUT_W];
  end

  mop_cpa #(.W(OUT_W)) cpa_i (
    .opa (cpa_a),
    .opb (cpa_b),
    .res (cpa_y)
  );

  if (PIPE) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        sum       <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          sum <= cpa_y;
        end
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign sum       = cpa_y;
  end

endmodule

// File: rtl/mop_adder_chk.sv
module mop_adder_chk #(
  parameter int NUM_OPS = 5,
  parameter int OP_W    = 8,
  parameter bit PIPE    = 1'b1,
  localparam int OUT_W    = csa_pkg::total_width(OP_W, NUM_OPS),
  localparam int NSTG     = NUM_OPS - 2,
  localparam int NSTG_ARR = (NSTG > 0) ? NSTG : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic [NUM_OPS*OP_W-1:0]   operands,
  input logic                      out_valid,
  input logic [OUT_W-1:0]          sum,
  input logic [NSTG_ARR*OUT_W-1:0] stg_x,
  input logic [NSTG_ARR*OUT_W-1:0] stg_y,
  input logic [NSTG_ARR*OUT_W-1:0] stg_z,
  input logic [NSTG_ARR*OUT_W-1:0] stg_s,
  input logic [NSTG_ARR*OUT_W-1:0] stg_c,
  input logic [OUT_W-1:0]          cpa_a,
  input logic [OUT_W-1:0]          cpa_b,
  input logic [OUT_W-1:0]          cpa_y
);

  // Behavioural total of the operands.
  logic [OUT_W-1:0] ref_sum;
  always_comb begin
    ref_sum = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      ref_sum = ref_sum + OUT_W'(operands[i*OP_W +: OP_W]);
    end
  end

  // R2: each row conserves the value of its three inputs.
  for (genvar j = 0; j < NSTG; j++) begin : g_row_chk
    logic [OUT_W-1:0] lhs;
    logic [OUT_W-1:0] rhs;
    assign lhs = stg_s[j*OUT_W +: OUT_W] + stg_c[j*OUT_W +: OUT_W];
    assign rhs = stg_x[j*OUT_W +: OUT_W] + stg_y[j*OUT_W +: OUT_W]
               + stg_z[j*OUT_W +: OUT_W];
    assert_stage_conserve_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lhs == rhs);
  end

  // R3: final adder resolves its pair.
  logic [OUT_W-1:0] cpa_ref;
  assign cpa_ref = cpa_a + cpa_b;
  assert_cpa_resolve_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpa_y == cpa_ref);

  if (PIPE) begin : g_pipe_chk
    assert_sum_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (sum == $past(ref_sum)));
    assert_valid_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(sum)));
  end else begin : g_comb_chk
    assert_sum_exact_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (sum == ref_sum));
  end

endmodule

bind mop_adder_top mop_adder_chk #(
  .NUM_OPS (NUM_OPS),
  .OP_W    (OP_W),
  .PIPE    (PIPE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .operands  (operands),
  .out_valid (out_valid),
  .sum       (sum),
  .stg_x     (stg_x),
  .stg_y     (stg_y),
  .stg_z     (stg_z),
  .stg_s     (stg_s),
  .stg_c     (stg_c),
  .cpa_a     (cpa_a),
  .cpa_b     (cpa_b),
  .cpa_y     (cpa_y)
);

// File: tb/mop_adder_top_tb.sv
module mop_adder_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // Main unit: five 8-bit operands, registered.
  logic        vin_m = 1'b0;
  logic [39:0] ops_m = '0;
  logic        vld_m;
  logic [10:0] sum_m;

  // Worked-example unit: four 4-bit operands, combinational.
  logic        vin_e = 1'b0;
  logic [15:0] ops_e = '0;
  logic        vld_e;
  logic [5:0]  sum_e;

  // Two-operand unit, registered.
  logic        vin_p = 1'b0;
  logic [15:0] ops_p = '0;
  logic        vld_p;
  logic [8:0]  sum_p;

  mop_adder_top #(.NUM_OPS(5), .OP_W(8), .PIPE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(vin_m), .operands(ops_m),
    .out_valid(vld_m), .sum(sum_m));

  mop_adder_top #(.NUM_OPS(4), .OP_W(4), .PIPE(1'b0)) dut_ex (
    .clk(clk), .rst_n(rst_n), .in_valid(vin_e), .operands(ops_e),
    .out_valid(vld_e), .sum(sum_e));

  mop_adder_top #(.NUM_OPS(2), .OP_W(8), .PIPE(1'b1)) dut_pair (
    .clk(clk), .rst_n(rst_n), .in_valid(vin_p), .operands(ops_p),
    .out_valid(vld_p), .sum(sum_p));

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  // Fixed vectors for the main unit: operands 0..4, expected total.
  localparam logic [7:0] TV_OPS [8][5] = '{
    '{8'd0,   8'd0,   8'd0,   8'd0,   8'd0},
    '{8'd1,   8'd2,   8'd3,   8'd4,   8'd5},
    '{8'd255, 8'd255, 8'd255, 8'd255, 8'd255},
    '{8'd128, 8'd128, 8'd128, 8'd128, 8'd128},
    '{8'd255, 8'd0,   8'd255, 8'd0,   8'd255},
    '{8'h55,  8'hAA,  8'h55,  8'hAA,  8'h01},
    '{8'd100, 8'd50,  8'd25,  8'd12,  8'd6},
    '{8'd200, 8'd201, 8'd202, 8'd203, 8'd204}
  };
  localparam logic [10:0] TV_EXP [8] = '{
    11'd0, 11'd15, 11'd1275, 11'd640, 11'd765, 11'd511, 11'd193, 11'd1010
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [10:0] main_total(input logic [39:0] v);
    logic [10:0] t = '0;
    for (int i = 0; i < 5; i++) t = t + {3'b000, v[8*i +: 8]};
    return t;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    logic [10:0] last;
    logic [39:0] a;
    logic [39:0] b;

    // R8: reset state, in_valid high during reset
    vin_m = 1'b1; ops_m = {5{8'hFF}};
    vin_p = 1'b1; ops_p = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R8 main out_valid in reset", 32'(vld_m), 32'd0);
    check("R8 main sum in reset", 32'(sum_m), 32'd0);
    check("R8 pair out_valid in reset", 32'(vld_p), 32'd0);
    vin_m = 1'b0; vin_p = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R7: table walk
    for (int t = 0; t < 8; t++) begin
      for (int i = 0; i < 5; i++) ops_m[8*i +: 8] = TV_OPS[t][i];
      vin_m = 1'b1;
      @(negedge clk);
      vin_m = 1'b0;
      check("R4 table out_valid", 32'(vld_m), 32'd1);
      check("R1 R2 R3 R7 table sum", 32'(sum_m), 32'(TV_EXP[t]));
    end

    // R1: random sets against bench total
    for (int r = 0; r < 40; r++) begin
      ops_m = {$urandom, $urandom_range(255, 0)};
      vin_m = 1'b1;
      a = ops_m;
      @(negedge clk);
      vin_m = 1'b0;
      check("R1 random sum", 32'(sum_m), 32'(main_total(a)));
    end

    // R4: back-to-back valid cycles
    a = {8'd9, 8'd8, 8'd7, 8'd6, 8'd5};
    b = {8'd250, 8'd1, 8'd240, 8'd2, 8'd230};
    ops_m = a; vin_m = 1'b1;
    @(negedge clk);
    check("R4 first of pair", 32'(sum_m), 32'd35);
    ops_m = b;
    @(negedge clk);
    check("R4 second of pair", 32'(sum_m), 32'd723);
    check("R4 second valid", 32'(vld_m), 32'd1);
    last = sum_m;

    // R9: idle cycles hold sum, drop valid
    vin_m = 1'b0; ops_m = {5{8'hFF}};
    @(negedge clk);
    check("R9 idle out_valid", 32'(vld_m), 32'd0);
    check("R9 idle sum held", 32'(sum_m), 32'(last));
    ops_m = 40'h0102030405;
    @(negedge clk);
    check("R9 second idle sum held", 32'(sum_m), 32'(last));

    // R8: reset pulse with in_valid high clears outputs
    vin_m = 1'b1; ops_m = {5{8'd77}};
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 mid-run reset out_valid", 32'(vld_m), 32'd0);
    check("R8 mid-run reset sum", 32'(sum_m), 32'd0);
    rst_n = 1'b1; vin_m = 1'b0;
    @(negedge clk);

    // R5 R10 R7: combinational 4 x 4-bit unit
    ops_e = {4'b0010, 4'b1101, 4'b0111, 4'b0001};
    vin_e = 1'b1;
    #1;
    check("R5 worked example", 32'(sum_e), 32'd23);
    check("R10 valid same cycle", 32'(vld_e), 32'd1);
    ops_e = 16'hFFFF;
    #1;
    check("R7 R10 all ones 4x4", 32'(sum_e), 32'd60);
    vin_e = 1'b0;
    #1;
    check("R10 valid drops same cycle", 32'(vld_e), 32'd0);

    // R6: two-operand unit
    @(negedge clk);
    ops_p = 16'hFFFF; vin_p = 1'b1;
    @(negedge clk);
    check("R6 R7 pair all ones", 32'(sum_p), 32'd510);
    for (int r = 0; r < 20; r++) begin
      ops_p = 16'($urandom);
      a = {24'd0, ops_p};
      @(negedge clk);
      check("R6 pair random", 32'(sum_p), 32'(a[7:0]) + 32'(a[15:8]));
    end
    vin_p = 1'b0;
    @(negedge clk);
    check("R6 pair idle valid", 32'(vld_p), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule